// File: doc/BRIEF.md
# Boot-Aware Code Fetch Address Generator

This block sits at the front of a segmented real-mode processor and produces the physical address of every instruction fetch. It holds three registers: the code-segment selector, a hidden segment base, and a 16-bit instruction pointer. The fetch address is the base plus the zero-extended pointer. Sequential advances, near jumps and far transfers change these registers. A far transfer loads a new selector, a new base and a new pointer together.

After reset the selector holds F000h, the hidden base holds FFFF0000h and the pointer holds FFF0h, so the first fetch lands at FFFFFFF0h. That address is 16 bytes below the top of a 4 GB space. A two-state machine controls a boot override. In state BOOT, entered on every reset, the upper 12 address bits are forced to ones and `boot_ovr` is high. The only transition, BOOT to PLAIN, happens at the clock edge that accepts the first far transfer. PLAIN persists until the next reset, and in PLAIN the address is the plain base-plus-offset sum.

A build-time option, `COMPAT20`, gives a 20-bit variant. It resets to selector FFFFh and pointer 0000h, so the first fetch is at FFFF0h. It forms addresses modulo 2^20 and starts directly in PLAIN.

Top module: `fetch_addr_gen`

## Requirements
- R1: With COMPAT20=0, the cycle after a synchronous reset shows `cs_sel`=F000h, `fetch_addr`=FFFFFFF0h and `boot_ovr`=1.
- R2: `fetch_addr` equals the hidden base plus the zero-extended 16-bit pointer, modulo 2^32. Outside BOOT the sum appears unmodified.
- R3: While `boot_ovr` is 1, bits 31:20 of `fetch_addr` are all ones.
- R4: When `far_en` is high, the next cycle shows `cs_sel`=`far_sel` and `fetch_addr`=`far_sel`×16+`far_ip`. The hidden base becomes `far_sel` shifted left by 4.
- R5: When `near_en` is high without `far_en`, only the pointer changes, to `near_ip`. The base, the selector and `boot_ovr` keep their values.
- R6: When `seq_en` is high alone, the pointer advances by `seq_len` modulo 2^16. The selector and `boot_ovr` are unchanged.
- R7: Priority in one cycle is far over near over sequential.
- R8: `boot_ovr` falls at the edge that accepts the first far transfer and stays 0 until the next reset.
- R9: With COMPAT20=1, reset gives `cs_sel`=FFFFh and `fetch_addr`=FFFF0h. Addresses wrap modulo 2^20 with bits 31:20 zero, and `boot_ovr` is never 1.
- R10: With no control input asserted, `fetch_addr`, `cs_sel` and `boot_ovr` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| seq_en | input | 1 | Advance pointer sequentially |
| seq_len | input | 4 | Advance amount in bytes |
| near_en | input | 1 | Near jump: load pointer only |
| near_ip | input | 16 | Near jump target offset |
| far_en | input | 1 | Far jump or call: reload segment and pointer |
| far_sel | input | 16 | Far transfer selector |
| far_ip | input | 16 | Far transfer offset |
| fetch_addr | output | 32 | Physical fetch address |
| cs_sel | output | 16 | Current code-segment selector |
| boot_ovr | output | 1 | Boot override active (state BOOT) |

## Verification
The address is combinational from the registers, so any corrupted register shows at the ports in the cycle after the edge that caused it. A stale BOOT state keeps bits 31:20 stuck at ones after a far transfer, even when the target is low in memory. A pointer that wraps wrongly or takes the wrong priority shows in the low address bits at once. A base loaded with the wrong shift makes far targets land 16 times off.

// File: rtl/fa_pkg.sv
package fa_pkg;
    typedef enum logic [0:0] {
        FM_BOOT  = 1'b0,
        FM_PLAIN = 1'b1
    } fetch_mode_e;

    typedef enum logic [1:0] {
        OP_HOLD = 2'd0,
        OP_SEQ  = 2'd1,
        OP_NEAR = 2'd2,
        OP_FAR  = 2'd3
    } ip_op_e;

    function automatic ip_op_e pick_op(input logic far_en, input logic near_en,
                                       input logic seq_en);
        ip_op_e op;
        if (far_en)       op = OP_FAR;
        else if (near_en) op = OP_NEAR;
        else if (seq_en)  op = OP_SEQ;
        else              op = OP_HOLD;
        return op;
    endfunction
endpackage

// File: rtl/fa_mode_fsm.sv
module fa_mode_fsm
    import fa_pkg::*;
#(
    parameter bit USE_BOOT = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic far_take,
    output logic ovr_on
);
    localparam fetch_mode_e START_MODE = USE_BOOT ? FM_BOOT : FM_PLAIN;

    fetch_mode_e mode_q;
    fetch_mode_e mode_d;

    always_comb begin
        mode_d = mode_q;
        unique case (mode_q)
            FM_BOOT:  if (far_take) mode_d = FM_PLAIN;
            FM_PLAIN: mode_d = FM_PLAIN;
            default:  mode_d = START_MODE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) mode_q <= START_MODE;
        else     mode_q <= mode_d;
    end

    always_comb begin
        unique case (mode_q)
            FM_BOOT:  ovr_on = 1'b1;
            FM_PLAIN: ovr_on = 1'b0;
            default:  ovr_on = 1'b0;
        endcase
    end
endmodule

// File: rtl/fa_seg_regs.sv
module fa_seg_regs
    import fa_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int SEL_W  = 16,
    parameter int IP_W   = 16,
    parameter int LEN_W  = 4,
    parameter logic [SEL_W-1:0]  RST_SEL  = '0,
    parameter logic [ADDR_W-1:0] RST_BASE = '0,
    parameter logic [IP_W-1:0]   RST_IP   = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              seq_en,
    input  logic [LEN_W-1:0]  seq_len,
    input  logic              near_en,
    input  logic [IP_W-1:0]   near_ip,
    input  logic              far_en,
    input  logic [SEL_W-1:0]  far_sel,
    input  logic [IP_W-1:0]   far_ip,
    output logic [SEL_W-1:0]  sel_q,
    output logic [ADDR_W-1:0] base_q,
    output logic [IP_W-1:0]   ip_q,
    output logic              far_take
);
    localparam int SHIFT = 4;

    ip_op_e op;
    logic [ADDR_W-1:0] far_base;

    assign op       = pick_op(far_en, near_en, seq_en);
    assign far_take = (op == OP_FAR);
    assign far_base = ADDR_W'({far_sel, {SHIFT{1'b0}}});

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q  <= RST_SEL;
            base_q <= RST_BASE;
            ip_q   <= RST_IP;
        end else begin
            unique case (op)
                OP_FAR: begin
                    sel_q  <= far_sel;
                    base_q <= far_base;
                    ip_q   <= far_ip;
                end
                OP_NEAR: ip_q <= near_ip;
                OP_SEQ:  ip_q <= ip_q + IP_W'(seq_len);
                OP_HOLD: ip_q <= ip_q;
                default: ip_q <= ip_q;
            endcase
        end
    end
endmodule

// File: rtl/fa_addr_form.sv
module fa_addr_form #(
    parameter int ADDR_W   = 32,
    parameter int IP_W     = 16,
    parameter int OVR_BITS = 12,
    parameter int PHYS_W   = 32,
    parameter bit NARROW   = 1'b0
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [IP_W-1:0]   ip,
    input  logic              ovr_on,
    output logic [ADDR_W-1:0] addr
);
    localparam logic [ADDR_W-1:0] OVR_MASK  = {{OVR_BITS{1'b1}}, {(ADDR_W-OVR_BITS){1'b0}}};
    localparam logic [ADDR_W-1:0] PHYS_MASK = ADDR_W'({PHYS_W{1'b1}});

    logic [ADDR_W-1:0] sum;
    assign sum = base + ADDR_W'(ip);

    generate
        if (NARROW) begin : g_narrow
            logic unused_ovr;
            assign unused_ovr = ovr_on;
            assign addr = sum & PHYS_MASK;
        end else begin : g_full
            assign addr = ovr_on ? (sum | OVR_MASK) : sum;
        end
    endgenerate
endmodule

// File: rtl/fetch_addr_gen.sv
module fetch_addr_gen #(
    parameter bit COMPAT20 = 1'b0,
    parameter int ADDR_W   = 32,
    parameter int SEL_W    = 16,
    parameter int IP_W     = 16,
    parameter int LEN_W    = 4,
    parameter int OVR_BITS = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              seq_en,
    input  logic [LEN_W-1:0]  seq_len,
    input  logic              near_en,
    input  logic [IP_W-1:0]   near_ip,
    input  logic              far_en,
    input  logic [SEL_W-1:0]  far_sel,
    input  logic [IP_W-1:0]   far_ip,
    output logic [ADDR_W-1:0] fetch_addr,
    output logic [SEL_W-1:0]  cs_sel,
    output logic              boot_ovr
);
    localparam int PHYS_W = COMPAT20 ? (SEL_W + 4) : ADDR_W;
    localparam logic [SEL_W-1:0] RST_SEL =
        COMPAT20 ? {SEL_W{1'b1}} : {4'hF, {(SEL_W-4){1'b0}}};
    localparam logic [ADDR_W-1:0] RST_BASE =
        COMPAT20 ? ADDR_W'({{SEL_W{1'b1}}, 4'h0})
                 : {{(ADDR_W-SEL_W){1'b1}}, {SEL_W{1'b0}}};
    localparam logic [IP_W-1:0] RST_IP =
        COMPAT20 ? {IP_W{1'b0}} : {{(IP_W-4){1'b1}}, 4'h0};

    logic [ADDR_W-1:0] base_q;
    logic [IP_W-1:0]   ip_q;
    logic              far_take;
    logic              ovr_on;

    fa_seg_regs #(
        .ADDR_W(ADDR_W), .SEL_W(SEL_W), .IP_W(IP_W), .LEN_W(LEN_W),
        .RST_SEL(RST_SEL), .RST_BASE(RST_BASE), .RST_IP(RST_IP)
    ) u_regs (
        .clk(clk), .rst(rst),
        .seq_en(seq_en), .seq_len(seq_len),
        .near_en(near_en), .near_ip(near_ip),
        .far_en(far_en), .far_sel(far_sel), .far_ip(far_ip),
        .sel_q(cs_sel), .base_q(base_q), .ip_q(ip_q), .far_take(far_take)
    );

    fa_mode_fsm #(.USE_BOOT(!COMPAT20)) u_fsm (
        .clk(clk), .rst(rst), .far_take(far_take), .ovr_on(ovr_on)
    );

    fa_addr_form #(
        .ADDR_W(ADDR_W), .IP_W(IP_W), .OVR_BITS(OVR_BITS),
        .PHYS_W(PHYS_W), .NARROW(COMPAT20)
    ) u_addr (
        .base(base_q), .ip(ip_q), .ovr_on(ovr_on), .addr(fetch_addr)
    );

    assign boot_ovr = ovr_on;
endmodule

// File: rtl/fetch_addr_gen_chk.sv
module fetch_addr_gen_chk #(
    parameter bit COMPAT20 = 1'b0,
    parameter int ADDR_W   = 32,
    parameter int SEL_W    = 16,
    parameter int IP_W     = 16,
    parameter int LEN_W    = 4,
    parameter int OVR_BITS = 12
) (
    input logic              clk,
    input logic              rst,
    input logic              seq_en,
    input logic [LEN_W-1:0]  seq_len,
    input logic              near_en,
    input logic [IP_W-1:0]   near_ip,
    input logic              far_en,
    input logic [SEL_W-1:0]  far_sel,
    input logic [IP_W-1:0]   far_ip,
    input logic [ADDR_W-1:0] fetch_addr,
    input logic [SEL_W-1:0]  cs_sel,
    input logic              boot_ovr
);
    localparam logic [ADDR_W-1:0] PMASK =
        COMPAT20 ? ADDR_W'({(SEL_W+4){1'b1}}) : {ADDR_W{1'b1}};
    localparam logic [ADDR_W-1:0] RST_ADDR =
        COMPAT20 ? ADDR_W'({{SEL_W{1'b1}}, 4'h0}) : {{(ADDR_W-4){1'b1}}, 4'h0};

    // R1 / R9: reset lands on the boot address
    a_r1_reset_addr: assert property (@(posedge clk)
        rst |=> (fetch_addr == RST_ADDR));

    // R3: override forces top bits
    a_r3_top_bits: assert property (@(posedge clk) disable iff (rst)
        boot_ovr |-> (&fetch_addr[ADDR_W-1 -: OVR_BITS]));

    // R4: far transfer target
    a_r4_far_target: assert property (@(posedge clk) disable iff (rst)
        far_en |=> (fetch_addr == ((ADDR_W'({$past(far_sel), 4'h0}) + ADDR_W'($past(far_ip))) & PMASK))
                   && (cs_sel == $past(far_sel)));

    // R8: override falls on a far transfer and never rises again
    a_r8_far_clears: assert property (@(posedge clk) disable iff (rst)
        far_en |=> !boot_ovr);
    a_r8_sticky_low: assert property (@(posedge clk) disable iff (rst)
        !boot_ovr |=> !boot_ovr);

    // R5: near jump keeps the mode and selector
    a_r5_near_keeps: assert property (@(posedge clk) disable iff (rst)
        (near_en && !far_en) |=> (boot_ovr == $past(boot_ovr)) && $stable(cs_sel));

    // R6: sequential advance moves the low address bits by seq_len
    a_r6_seq_step: assert property (@(posedge clk) disable iff (rst)
        (seq_en && !near_en && !far_en) |=>
            (fetch_addr[IP_W-1:0] == $past(fetch_addr[IP_W-1:0]) + IP_W'($past(seq_len))));

    // R9: narrow variant never raises the override
    a_r9_no_boot: assert property (@(posedge clk) disable iff (rst)
        !(COMPAT20 && boot_ovr));

    // R10: idle cycles hold everything
    a_r10_hold: assert property (@(posedge clk) disable iff (rst)
        (!seq_en && !near_en && !far_en) |=> $stable(fetch_addr) && $stable(boot_ovr));
endmodule

bind fetch_addr_gen fetch_addr_gen_chk #(
    .COMPAT20(COMPAT20), .ADDR_W(ADDR_W), .SEL_W(SEL_W),
    .IP_W(IP_W), .LEN_W(LEN_W), .OVR_BITS(OVR_BITS)
) u_chk (
    .clk(clk), .rst(rst), .seq_en(seq_en), .seq_len(seq_len),
    .near_en(near_en), .near_ip(near_ip), .far_en(far_en),
    .far_sel(far_sel), .far_ip(far_ip), .fetch_addr(fetch_addr),
    .cs_sel(cs_sel), .boot_ovr(boot_ovr)
);

// File: tb/fetch_addr_gen_test.sv
module fetch_addr_gen_test;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        seq_en = 1'b0;
    logic [3:0]  seq_len = '0;
    logic        near_en = 1'b0;
    logic [15:0] near_ip = '0;
    logic        far_en = 1'b0;
    logic [15:0] far_sel = '0;
    logic [15:0] far_ip = '0;

    logic [31:0] addr_w, addr_c;
    logic [15:0] sel_w, sel_c;
    logic        ovr_w, ovr_c;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // model state
    logic [15:0] m_sel, m_ip, c_sel, c_ip;
    logic [31:0] m_base, c_base;
    logic        m_ovr;

    always #(CLK_P/2) clk = ~clk;

    fetch_addr_gen uut (
        .clk(clk), .rst(rst), .seq_en(seq_en), .seq_len(seq_len),
        .near_en(near_en), .near_ip(near_ip), .far_en(far_en),
        .far_sel(far_sel), .far_ip(far_ip),
        .fetch_addr(addr_w), .cs_sel(sel_w), .boot_ovr(ovr_w)
    );

    fetch_addr_gen #(.COMPAT20(1'b1)) uut_c (
        .clk(clk), .rst(rst), .seq_en(seq_en), .seq_len(seq_len),
        .near_en(near_en), .near_ip(near_ip), .far_en(far_en),
        .far_sel(far_sel), .far_ip(far_ip),
        .fetch_addr(addr_c), .cs_sel(sel_c), .boot_ovr(ovr_c)
    );

    function automatic logic [31:0] exp_wide(logic [31:0] b, logic [15:0] ip, logic ovr);
        logic [31:0] s;
        s = b + {16'h0, ip};
        return ovr ? (s | 32'hFFF0_0000) : s;
    endfunction

    function automatic logic [31:0] exp_narrow(logic [31:0] b, logic [15:0] ip);
        return (b + {16'h0, ip}) & 32'h000F_FFFF;
    endfunction

    task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic cyc(string tag, bit r, bit s, logic [3:0] l, bit n, logic [15:0] nip,
                       bit f, logic [15:0] fs, logic [15:0] fi);
        rst = r; seq_en = s; seq_len = l; near_en = n; near_ip = nip;
        far_en = f; far_sel = fs; far_ip = fi;
        if (r) begin
            m_sel = 16'hF000; m_base = 32'hFFFF_0000; m_ip = 16'hFFF0; m_ovr = 1'b1;
            c_sel = 16'hFFFF; c_base = 32'h000F_FFF0; c_ip = 16'h0000;
        end else if (f) begin
            m_sel = fs; m_base = {12'h0, fs, 4'h0}; m_ip = fi; m_ovr = 1'b0;
            c_sel = fs; c_base = {12'h0, fs, 4'h0}; c_ip = fi;
        end else if (n) begin
            m_ip = nip; c_ip = nip;
        end else if (s) begin
            m_ip = m_ip + {12'h0, l}; c_ip = c_ip + {12'h0, l};
        end
        @(negedge clk);
        check({tag, " addr"}, addr_w, exp_wide(m_base, m_ip, m_ovr));
        check({tag, " ovr"}, {31'h0, ovr_w}, {31'h0, m_ovr});
        check({tag, " sel"}, {16'h0, sel_w}, {16'h0, m_sel});
        check({tag, " R9 addr"}, addr_c, exp_narrow(c_base, c_ip));
        check({tag, " R9 ovr"}, {31'h0, ovr_c}, 32'h0);
        check({tag, " R9 sel"}, {16'h0, sel_c}, {16'h0, c_sel});
    endtask

    initial begin
        #(CLK_P * 150000);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h1234_5678));
        @(negedge clk);
        cyc("R1 reset", 1, 0, 0, 0, 0, 0, 0, 0);
        check("R1 first fetch", addr_w, 32'hFFFF_FFF0);
        check("R9 first fetch", addr_c, 32'h000F_FFF0);
        cyc("R10 idle", 0, 0, 0, 0, 0, 0, 0, 0);
        cyc("R6 seq", 0, 1, 4'd7, 0, 0, 0, 0, 0);
        cyc("R6 seq wrap", 0, 1, 4'd15, 0, 0, 0, 0, 0);
        cyc("R5 near top", 0, 0, 0, 1, 16'hFFFF, 0, 0, 0);
        cyc("R3 near low", 0, 0, 0, 1, 16'h0000, 0, 0, 0);
        cyc("R7 near beats seq", 0, 1, 4'd3, 1, 16'h1234, 0, 0, 0);
        cyc("R7 far beats near", 0, 1, 4'd5, 1, 16'h9999, 1, 16'h0010, 16'h0100);
        check("R4 far addr", addr_w, 32'h0000_0200);
        cyc("R8 stays low", 0, 0, 0, 1, 16'h0020, 0, 0, 0);
        cyc("R4 far max", 0, 0, 0, 0, 0, 1, 16'hFFFF, 16'hFFFF);
        check("R2 no wrap 32", addr_w, 32'h0010_FFEF);
        check("R9 wrap 20", addr_c, 32'h0000_FFEF);
        cyc("R10 idle2", 0, 0, 0, 0, 0, 0, 0, 0);
        cyc("R1 re-reset", 1, 0, 0, 0, 0, 0, 0, 0);
        cyc("R6 seq boot", 0, 1, 4'd1, 0, 0, 0, 0, 0);
        for (int i = 0; i < 600; i++) begin
            int unsigned k;
            k = $urandom_range(0, 99);
            cyc("R2 R7 random", k < 2, $urandom_range(0, 1) == 1, 4'($urandom),
                $urandom_range(0, 3) == 0, 16'($urandom),
                $urandom_range(0, 15) == 0, 16'($urandom), 16'($urandom));
        end
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule